// File: doc/BRIEF.md
# Single-Channel Bus-Mastering Block Mover

The block moves a block of words between one I/O device and system memory without the processor handling each word. Software first sets up a start address, a word count and a control word through a small register port. That port answers only while the processor owns the bus. When a launch comes in, either from a start bit written by software or from a request pin on the device, the engine asks the processor for the bus. Once the processor grants the bus, the engine drives memory addresses and read or write strobes itself. After each word it advances the address and lowers the count.

Three ownership policies are available. In block mode the engine keeps the bus until the last word. In stealing mode it gives the bus back after every word and asks again for the next one. In idle-slot mode it moves a word only when the processor reports that its current cycle leaves the bus unused. When the count is used up and the bus has been handed back, the engine raises an interrupt and sets a done flag. The interrupt stays up until software touches the control register.

The state machine has seven states:

| State | What it does | Leaves for |
|---|---|---|
| ST_IDLE | Waits for a launch. | ST_REQ on a launch with a non-zero count. On a launch with a zero count it stays in ST_IDLE and signals completion at once. |
| ST_REQ | Holds the bus request high. | ST_ADDR once grant is high. In idle-slot mode, `cpu_idle` must also be high. |
| ST_ADDR | Presents the memory address. | ST_STRB. |
| ST_STRB | Raises the read or write strobe. | ST_CAPT once `mem_rdy` is high. |
| ST_CAPT | Pulses `io_stb` and steps the address and count. | On the last word, ST_FIN. Otherwise ST_ADDR in block mode, ST_GAP in stealing mode, ST_REQ in idle-slot mode. |
| ST_GAP | Releases the request. | ST_REQ once grant is low. |
| ST_FIN | Releases the request. | ST_IDLE once grant is low, signalling completion. |

Top module: `dma_engine`

## Requirements
- R1: After reset, `bus_req`, `irq`, `dack`, `mem_rd`, `mem_wr` and `io_stb` are low, and all three registers read as zero.
- R2: The register port is reached through `sel` with `reg_rd` or `reg_wr`. `rsel` picks the register: 0 is the address, 1 is the word count, 2 is control. Control bits are: bit 0 start (write only), bit 1 direction (0 = device to memory, 1 = memory to device), bits 3:2 mode (00 block, 01 stealing, 10 idle-slot, 11 block), bit 4 done (read only), bit 5 busy (read only). Accesses made while `bus_gnt` is high are ignored, and `rdata` is zero. Configuration writes made while busy are ignored.
- R3: A launch raises `bus_req`. No strobe appears unless `bus_gnt` is high.
- R4: Each moved word raises the address by one and lowers the count by one. Device-to-memory writes the device's words to consecutive addresses. Memory-to-device hands the memory words to the device in address order.
- R5: In block mode `bus_req` rises exactly once per transfer and stays high until the last word.
- R6: In stealing mode `bus_req` rises once per word. At most one word moves per grant period. The request rises again only after grant is low.
- R7: In idle-slot mode no word starts while `cpu_idle` is low.
- R8: On completion `irq` rises after `bus_req` and `bus_gnt` are both low, and the done bit reads 1. A read or a write of the control register clears `irq`. The done flag remains set.
- R9: A launch with a word count of zero raises `irq` in the next cycle and never raises `bus_req`.
- R10: A `dreq` seen while the engine is idle launches the transfer and produces a one-cycle `dack`. A `dreq` seen while the engine is busy is not acknowledged.
- R11: A strobe is held while `mem_rdy` is low, so each word gets exactly one accepted memory write. Read and write strobes are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| sel | input | 1 | Register port select |
| rsel | input | 2 | Register index |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| wdata | input | DW | Register write data |
| rdata | output | DW | Register read data (zero when not read) |
| bus_req | output | 1 | Bus ownership request |
| bus_gnt | input | 1 | Bus granted by the processor |
| cpu_idle | input | 1 | Processor's current cycle leaves the bus free |
| dreq | input | 1 | Device launch request |
| dack | output | 1 | Device request acknowledge |
| mem_addr | output | AW | Memory word address |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | DW | Data to memory |
| mem_rdata | input | DW | Data from memory |
| mem_rdy | input | 1 | Memory ready; low stretches the strobe |
| io_rdata | input | DW | Word supplied by the device |
| io_wdata | output | DW | Word delivered to the device |
| io_stb | output | 1 | One pulse per word moved |
| irq | output | 1 | Completion interrupt |

## Verification
The properties assume the processor side behaves like a real arbiter. Grant is raised only while a request is pending. Grant is dropped within one cycle of the request falling. The register port is not used to change the count while the bus is granted. The bench's arbiter model follows these rules and only randomises how long it waits before granting. It also randomises memory ready and the processor's idle signal on each cycle. A single directed step forces grant high while the engine is idle, to check that the register port is shut off.

// File: rtl/dma_pkg.sv
package dma_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_ADDR,
        ST_STRB,
        ST_CAPT,
        ST_GAP,
        ST_FIN
    } dma_state_e;

    typedef enum logic [1:0] {
        MODE_BLOCK  = 2'b00,
        MODE_STEAL  = 2'b01,
        MODE_SLOT   = 2'b10,
        MODE_BLOCK2 = 2'b11
    } dma_mode_e;

    localparam logic [1:0] RSEL_ADDR = 2'd0;
    localparam logic [1:0] RSEL_CNT  = 2'd1;
    localparam logic [1:0] RSEL_CTRL = 2'd2;

    localparam int CTRL_START   = 0;
    localparam int CTRL_DIR     = 1;
    localparam int CTRL_MODE_LO = 2;
    localparam int CTRL_MODE_HI = 3;
    localparam int CTRL_DONE    = 4;
    localparam int CTRL_BUSY    = 5;

endpackage

// File: rtl/dma_regs.sv
module dma_regs
    import dma_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 16,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel,
    input  logic [1:0]    rsel,
    input  logic          reg_rd,
    input  logic          reg_wr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    input  logic          bus_gnt,
    input  logic          busy,
    input  logic          word_done,
    input  logic          finish,
    output logic          go,
    output logic [AW-1:0] addr_q,
    output logic [CW-1:0] cnt_q,
    output logic          dir_q,
    output dma_mode_e     mode_q,
    output logic          irq
);

    logic acc_wr, acc_rd, ctrl_hit, done_q;

    // The processor owns the port only while it also owns the bus.
    assign acc_wr   = sel & reg_wr & ~bus_gnt;
    assign acc_rd   = sel & reg_rd & ~bus_gnt;
    assign ctrl_hit = (rsel == RSEL_CTRL);
    assign go       = acc_wr & ctrl_hit & wdata[CTRL_START] & ~busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            cnt_q  <= '0;
            dir_q  <= 1'b0;
            mode_q <= MODE_BLOCK;
            done_q <= 1'b0;
            irq    <= 1'b0;
        end else begin
            if (acc_wr && !busy) begin
                case (rsel)
                    RSEL_ADDR: addr_q <= wdata[AW-1:0];
                    RSEL_CNT:  cnt_q  <= wdata[CW-1:0];
                    RSEL_CTRL: begin
                        dir_q  <= wdata[CTRL_DIR];
                        mode_q <= dma_mode_e'(wdata[CTRL_MODE_HI:CTRL_MODE_LO]);
                    end
                    default: ;
                endcase
            end
            if (word_done) begin
                addr_q <= addr_q + 1'b1;
                cnt_q  <= cnt_q - 1'b1;
            end
            if (go)     done_q <= 1'b0;
            if (finish) done_q <= 1'b1;
            if ((acc_wr || acc_rd) && ctrl_hit) irq <= 1'b0;
            if (finish) irq <= 1'b1;
        end
    end

    always_comb begin
        rdata = '0;
        if (acc_rd) begin
            case (rsel)
                RSEL_ADDR: rdata[AW-1:0] = addr_q;
                RSEL_CNT:  rdata[CW-1:0] = cnt_q;
                RSEL_CTRL: begin
                    rdata[CTRL_DIR]                  = dir_q;
                    rdata[CTRL_MODE_HI:CTRL_MODE_LO] = mode_q;
                    rdata[CTRL_DONE]                 = done_q;
                    rdata[CTRL_BUSY]                 = busy;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/dma_fsm.sv
module dma_fsm
    import dma_pkg::*;
#(
    parameter int CW = 16,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic          dreq,
    input  logic          bus_gnt,
    input  logic          cpu_idle,
    input  logic          mem_rdy,
    input  dma_mode_e     mode,
    input  logic          dir,
    input  logic [CW-1:0] cnt_q,
    input  logic [DW-1:0] mem_rdata,
    input  logic [DW-1:0] io_rdata,
    output logic          bus_req,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [DW-1:0] mem_wdata,
    output logic [DW-1:0] io_wdata,
    output logic          io_stb,
    output logic          dack,
    output logic          word_done,
    output logic          finish,
    output logic          busy
);

    dma_state_e state, nxt;
    logic [DW-1:0] rd_buf;
    logic          last_word, launch, slot_ok;

    assign launch    = go | dreq;
    assign last_word = (cnt_q == CW'(1));
    assign slot_ok   = (mode != MODE_SLOT) | cpu_idle;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (launch && cnt_q != '0) nxt = ST_REQ;
            ST_REQ:  if (bus_gnt && slot_ok) nxt = ST_ADDR;
            ST_ADDR: nxt = ST_STRB;
            ST_STRB: if (mem_rdy) nxt = ST_CAPT;
            ST_CAPT: begin
                if (last_word)               nxt = ST_FIN;
                else if (mode == MODE_STEAL) nxt = ST_GAP;
                else if (mode == MODE_SLOT)  nxt = ST_REQ;
                else                         nxt = ST_ADDR;
            end
            ST_GAP:  if (!bus_gnt) nxt = ST_REQ;
            ST_FIN:  if (!bus_gnt) nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        bus_req   = 1'b0;
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        io_stb    = 1'b0;
        word_done = 1'b0;
        finish    = 1'b0;
        unique case (state)
            ST_IDLE: finish = launch & (cnt_q == '0);
            ST_REQ:  bus_req = 1'b1;
            ST_ADDR: bus_req = 1'b1;
            ST_STRB: begin
                bus_req = 1'b1;
                mem_rd  = dir;
                mem_wr  = ~dir;
            end
            ST_CAPT: begin
                bus_req   = 1'b1;
                io_stb    = 1'b1;
                word_done = 1'b1;
            end
            ST_GAP:  ;
            ST_FIN:  finish = ~bus_gnt;
            default: ;
        endcase
    end

    assign busy      = (state != ST_IDLE);
    assign mem_wdata = io_rdata;
    assign io_wdata  = rd_buf;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_buf <= '0;
            dack   <= 1'b0;
        end else begin
            dack <= (state == ST_IDLE) & dreq;
            if (state == ST_STRB && mem_rdy && dir) rd_buf <= mem_rdata;
        end
    end

endmodule

// File: rtl/dma_engine.sv
module dma_engine
    import dma_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 16,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel,
    input  logic [1:0]    rsel,
    input  logic          reg_rd,
    input  logic          reg_wr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          bus_req,
    input  logic          bus_gnt,
    input  logic          cpu_idle,
    input  logic          dreq,
    output logic          dack,
    output logic [AW-1:0] mem_addr,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_rdy,
    input  logic [DW-1:0] io_rdata,
    output logic [DW-1:0] io_wdata,
    output logic          io_stb,
    output logic          irq
);

    logic [AW-1:0] addr_q;
    logic [CW-1:0] cnt_q;
    logic          dir_q, go, busy, word_done, finish;
    dma_mode_e     mode_q;

    dma_regs #(.AW(AW), .CW(CW), .DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n), .sel(sel), .rsel(rsel),
        .reg_rd(reg_rd), .reg_wr(reg_wr), .wdata(wdata), .rdata(rdata),
        .bus_gnt(bus_gnt), .busy(busy), .word_done(word_done),
        .finish(finish), .go(go), .addr_q(addr_q), .cnt_q(cnt_q),
        .dir_q(dir_q), .mode_q(mode_q), .irq(irq)
    );

    dma_fsm #(.CW(CW), .DW(DW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .go(go), .dreq(dreq), .bus_gnt(bus_gnt),
        .cpu_idle(cpu_idle), .mem_rdy(mem_rdy), .mode(mode_q), .dir(dir_q),
        .cnt_q(cnt_q), .mem_rdata(mem_rdata), .io_rdata(io_rdata),
        .bus_req(bus_req), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_wdata(mem_wdata), .io_wdata(io_wdata), .io_stb(io_stb),
        .dack(dack), .word_done(word_done), .finish(finish), .busy(busy)
    );

    assign mem_addr = addr_q;

endmodule

// File: rtl/dma_engine_chk.sv
module dma_engine_chk #(
    parameter int AW = 16,
    parameter int CW = 16,
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_req,
    input logic          bus_gnt,
    input logic          mem_rd,
    input logic          mem_wr,
    input logic          io_stb,
    input logic          irq,
    input logic          dack,
    input logic          busy,
    input logic [DW-1:0] rdata,
    input logic [AW-1:0] addr,
    input logic [CW-1:0] cnt
);

    // R3
    strobe_needs_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_wr) |-> bus_gnt);

    // R11
    one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    // R2
    port_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_gnt |-> (rdata == '0));

    // R4
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        io_stb |=> (cnt == CW'($past(cnt) - 1'b1)));

    // R4
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        io_stb |=> (addr == AW'($past(addr) + 1'b1)));

    // R8
    irq_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> (!bus_req && !bus_gnt));

    // R6
    rerequest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_req) |-> !bus_gnt);

    // R10
    dack_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dack |-> !$past(busy));

endmodule

bind dma_engine dma_engine_chk #(.AW(AW), .CW(CW), .DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_gnt(bus_gnt),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .io_stb(io_stb), .irq(irq),
    .dack(dack), .busy(busy), .rdata(rdata), .addr(addr_q), .cnt(cnt_q)
);

// File: tb/dma_engine_test.sv
module dma_engine_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel = 1'b0, reg_rd = 1'b0, reg_wr = 1'b0;
    logic [1:0]  rsel = 2'd0;
    logic [15:0] wdata = '0, rdata;
    logic        bus_req, bus_gnt, cpu_idle, dreq = 1'b0, dack;
    logic [15:0] mem_addr, mem_wdata, mem_rdata, io_rdata, io_wdata;
    logic        mem_rd, mem_wr, mem_rdy, io_stb, irq;

    logic        gnt_force = 1'b0, idle_force = 1'b0, dev_clr = 1'b0;
    logic [1:0]  cur_mode = 2'd0;
    int          xfer_tag = 0;
    logic [15:0] mem [0:255];
    logic [15:0] dev_got [0:15];
    logic [3:0]  dev_idx;

    int n_checks = 0, n_fail = 0;
    int viol = 0, wr_cnt = 0, rises = 0, steal_viol = 0, dack_cnt = 0, wpg = 0;
    logic prev_req = 1'b0;

    always #10 clk = ~clk;

    dma_engine uut (
        .clk(clk), .rst_n(rst_n), .sel(sel), .rsel(rsel), .reg_rd(reg_rd),
        .reg_wr(reg_wr), .wdata(wdata), .rdata(rdata), .bus_req(bus_req),
        .bus_gnt(bus_gnt), .cpu_idle(cpu_idle), .dreq(dreq), .dack(dack),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_rdy(mem_rdy),
        .io_rdata(io_rdata), .io_wdata(io_wdata), .io_stb(io_stb), .irq(irq)
    );

    function automatic logic [15:0] dev_pat(input int tag, input int i);
        return 16'(32'hC000 + tag * 256 + i * 7);
    endfunction

    function automatic logic [15:0] mem_init(input int a);
        return 16'(a * 37 + 5);
    endfunction

    assign io_rdata  = dev_pat(xfer_tag, int'(dev_idx));
    assign mem_rdata = mem[mem_addr[7:0]];

    // processor arbiter, memory and device models
    always @(posedge clk) begin
        if (!rst_n) begin
            bus_gnt  <= 1'b0;
            mem_rdy  <= 1'b0;
            cpu_idle <= 1'b0;
            dev_idx  <= '0;
            for (int i = 0; i < 256; i++) mem[i] <= mem_init(i);
        end else begin
            bus_gnt  <= gnt_force | (bus_req & (bus_gnt | ($urandom % 2 == 1)));
            mem_rdy  <= ($urandom % 4) != 0;
            cpu_idle <= idle_force ? 1'b0 : ($urandom % 3 == 0);
            if (dev_clr)     dev_idx <= '0;
            else if (io_stb) dev_idx <= dev_idx + 1'b1;
            if (io_stb) dev_got[dev_idx] <= io_wdata;
            if (mem_wr && mem_rdy) mem[mem_addr[7:0]] <= mem_wdata;
        end
    end

    // free-running port monitors
    always @(negedge clk) begin
        if (rst_n) begin
            if ((mem_rd || mem_wr) && !bus_gnt) viol++;
            if (mem_wr && mem_rdy) wr_cnt++;
            if (bus_req && !prev_req) rises++;
            prev_req = bus_req;
            if (dack) dack_cnt++;
            if (io_stb) begin
                if (wpg >= 1 && cur_mode == 2'b01) steal_viol++;
                wpg++;
            end
            if (!bus_gnt) wpg = 0;
        end
    end

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] r, input logic [15:0] d);
        @(negedge clk);
        sel = 1'b1; reg_wr = 1'b1; rsel = r; wdata = d;
        @(negedge clk);
        sel = 1'b0; reg_wr = 1'b0; wdata = '0;
    endtask

    task automatic reg_read(input logic [1:0] r, output logic [15:0] d);
        @(negedge clk);
        sel = 1'b1; reg_rd = 1'b1; rsel = r;
        #1 d = rdata;
        @(negedge clk);
        sel = 1'b0; reg_rd = 1'b0;
    endtask

    task automatic wait_irq();
        for (int i = 0; i < 4000; i++) begin
            if (irq) break;
            @(negedge clk);
        end
    endtask

    // how: 0 = start bit, 1 = device request; hold = keep the processor busy for a while
    task automatic xfer(input int a, input int n, input logic d, input logic [1:0] m,
                        input bit how, input bit hold);
        int r0, w0, v0, s0, k0, bad;
        logic [15:0] v;
        xfer_tag++;
        cur_mode = m;
        @(negedge clk) dev_clr = 1'b1;
        @(negedge clk) dev_clr = 1'b0;
        reg_write(2'd0, 16'(a));
        reg_write(2'd1, 16'(n));
        r0 = rises; w0 = wr_cnt; v0 = viol; s0 = steal_viol; k0 = dack_cnt;
        idle_force = hold;
        if (how) begin
            reg_write(2'd2, {12'd0, m, d, 1'b0});
            @(negedge clk) dreq = 1'b1;
            @(negedge clk) dreq = 1'b0;
            // R10: acknowledged while idle
            chk(dack == 1'b1, "R10 dack when idle", int'(dack), 1);
            repeat (3) @(negedge clk);
            dreq = 1'b1;
            repeat (3) @(negedge clk);
            dreq = 1'b0;
        end else begin
            reg_write(2'd2, {12'd0, m, d, 1'b1});
        end
        if (hold) begin
            repeat (40) @(negedge clk);
            // R7: nothing moves while the processor uses the bus
            chk(wr_cnt == w0 && bus_req, "R7 no word without idle slot", wr_cnt - w0, 0);
            idle_force = 1'b0;
        end
        wait_irq();
        chk(irq == 1'b1, "R8 irq at completion", int'(irq), 1);
        chk(!bus_req && !bus_gnt, "R8 bus released", int'({bus_req, bus_gnt}), 0);
        chk(viol == v0, "R3 strobe only under grant", viol - v0, 0);
        if (how) chk(dack_cnt - k0 == 1, "R10 no dack while busy", dack_cnt - k0, 1);
        if (m == 2'b00 || m == 2'b11)
            chk(rises - r0 == 1, "R5 single request in block mode", rises - r0, 1);
        if (m == 2'b01) begin
            chk(rises - r0 == n, "R6 one request per word", rises - r0, n);
            chk(steal_viol == s0, "R6 one word per grant", steal_viol - s0, 0);
        end
        bad = 0;
        for (int i = 0; i < n; i++) begin
            if (!d && mem[(a + i) % 256] != dev_pat(xfer_tag, i)) bad++;
            if (d && dev_got[i] != mem[(a + i) % 256]) bad++;
        end
        chk(bad == 0, "R4 data order and placement", bad, 0);
        if (!d) chk(wr_cnt - w0 == n, "R11 one write per word", wr_cnt - w0, n);
        reg_read(2'd0, v);
        chk(v == 16'(a + n), "R4 address advanced", int'(v), a + n);
        reg_read(2'd1, v);
        chk(v == 16'd0, "R4 count exhausted", int'(v), 0);
        reg_read(2'd2, v);
        chk(v == {10'd0, 1'b0, 1'b1, m, d, 1'b0}, "R8 done bit",
            int'(v), int'({10'd0, 1'b0, 1'b1, m, d, 1'b0}));
        chk(irq == 1'b0, "R8 read clears irq", int'(irq), 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin : stim
        logic [15:0] v;
        int r0;
        void'($urandom(32'd7321));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(!bus_req && !irq && !dack && !mem_rd && !mem_wr && !io_stb, "R1 outputs idle",
            int'({bus_req, irq, dack, mem_rd, mem_wr, io_stb}), 0);
        reg_read(2'd0, v); chk(v == 0, "R1 address reg", int'(v), 0);
        reg_read(2'd1, v); chk(v == 0, "R1 count reg", int'(v), 0);
        reg_read(2'd2, v); chk(v == 0, "R1 control reg", int'(v), 0);

        // R2 register port and grant gating
        reg_write(2'd0, 16'h0040);
        reg_write(2'd1, 16'd5);
        reg_write(2'd2, 16'h0006);
        reg_read(2'd0, v); chk(v == 16'h0040, "R2 address readback", int'(v), 'h40);
        reg_read(2'd1, v); chk(v == 16'd5, "R2 count readback", int'(v), 5);
        reg_read(2'd2, v); chk(v == 16'h0006, "R2 control readback", int'(v), 6);
        gnt_force = 1'b1;
        repeat (2) @(negedge clk);
        reg_write(2'd0, 16'h1234);
        reg_read(2'd0, v); chk(v == 16'h0, "R2 port silent under grant", int'(v), 0);
        gnt_force = 1'b0;
        repeat (2) @(negedge clk);
        reg_read(2'd0, v); chk(v == 16'h0040, "R2 write under grant ignored", int'(v), 'h40);

        // R9 zero-length launch
        reg_write(2'd1, 16'd0);
        r0 = rises;
        reg_write(2'd2, 16'h0001);
        chk(irq == 1'b1, "R9 immediate irq", int'(irq), 1);
        chk(rises == r0 && !bus_req, "R9 no bus request", rises - r0, 0);
        reg_write(2'd2, 16'h0000);
        chk(irq == 1'b0, "R8 control write clears irq", int'(irq), 0);

        // directed transfers
        xfer(16'h10, 6, 1'b0, 2'b00, 1'b0, 1'b0);  // R5 block, device to memory
        xfer(16'h30, 4, 1'b1, 2'b01, 1'b0, 1'b0);  // R6 stealing, memory to device
        xfer(16'h50, 3, 1'b0, 2'b10, 1'b0, 1'b1);  // R7 idle-slot with processor busy
        xfer(16'h70, 3, 1'b0, 2'b00, 1'b1, 1'b0);  // R10 device launch
        xfer(16'hFE, 1, 1'b1, 2'b11, 1'b0, 1'b0);  // single word, mode 11 as block

        // constrained random transfers
        for (int k = 0; k < 10; k++) begin
            xfer(int'($urandom % 200), int'($urandom % 8) + 1, 1'($urandom % 2),
                 2'($urandom % 4), 1'($urandom % 2), 1'b0);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule